// File: doc/BRIEF.md
# Hybrid Carry-Select Lookahead Adder

This block is a purely combinational 64-bit two-operand adder with a carry input and a carry output. The operands are cut into eight 8-bit slices. Every slice works out two results in parallel: one that assumes no carry arrives from below, and one that assumes a carry does arrive. The carry that actually reaches each slice comes from a prefix tree. The tree is built from radix-4 combining cells, each of which merges four propagate/generate pairs and reports three cumulative prefixes. Each slice carry then drives an 8-bit two-way multiplexer that picks one of the two precomputed results.

The tree has three levels. The first level reduces bits 55:0 to 4-bit ranges. The carry input is folded into the generate term of bits 3:0. The second level forms the ranges 7:0, 15:0, 23:16, 31:16, 39:32, 47:32 and 55:48, which already give the carries into bits 8 and 16. The third level has two cells. The first cell chains 15:0, 23:16, 31:16 and 39:32 into the carries for bits 24, 32 and 40. The second cell chains 15:0, 31:16, 47:32 and 55:48 into the carries for bits 48 and 56. Both cells produce the prefix over bits 31:0, each along its own path.

The block has no clock and no state. It is placed wherever a wide add must settle in a single cycle of the surrounding logic.

Top module: `hybrid_csla_adder`

## Requirements
- R1: `sum` equals the low 64 bits of `a + b + cin` for every operand pair.
- R2: `cout` equals bit 64 of the 65-bit result of `a + b + cin`.
- R3: In each 8-bit slice, the result assuming carry 1 equals the result assuming carry 0 plus one, taken as 9-bit values {carry, sum}.
- R4: The carry that selects slice k (k = 1..7, entering bit 8k) equals the carry leaving slice k-1 under that slice's own selected carry. An operand of 2^(8k)-1 added to 1 gives exactly 2^(8k).
- R5: The carry input is absorbed into the lowest 4-bit range. All-ones plus zero with `cin` = 1 gives `sum` = 0 and `cout` = 1.
- R6: When every bit only propagates (b = ~a) and `cin` = 0, no carry appears anywhere: `sum` is all ones and `cout` = 0. This holds for the all-ones/zero pair and for the alternating 0x5555…/0xAAAA… pair.
- R7: The two third-level paths that form the prefix over bits 31:0 agree. A carry out of bit 31 reaches bit 32, so 0x00000000_FFFFFFFF + 1 = 0x00000001_00000000.
- R8: A range reports propagate only when each of its sub-ranges does. With b = ~a and `cin` = 1, the carry travels the full width: `sum` = 0 and `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of the total |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench builds the block with its default sizes: a 64-bit width, 8-bit slices and 4-bit first-level ranges. At these sizes every one of the seven slice boundaries is a distinct tree output, and a directed add of 2^(8k)-1 and 1 drives a carry across each boundary in turn. The all-propagate pairs, with the carry input both clear and set, reach the longest carry path through all three tree levels. Random operands with a fixed seed mix generate and propagate runs that begin and end at arbitrary bits within the slices.

// File: rtl/hcsa_pkg.sv
package hcsa_pkg;
    localparam int ADD_W   = 64;
    localparam int GRP_W   = 8;
    localparam int NUM_GRP = ADD_W / GRP_W;
    localparam int NIB_W   = 4;
    localparam int TREE_W  = ADD_W - GRP_W;
    localparam int NUM_NIB = TREE_W / NIB_W;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    localparam pg_t PG_IDENT = '{p: 1'b1, g: 1'b0};

    // combine a higher range with the adjacent (or overlapping) lower range
    function automatic pg_t pg_merge(pg_t hi, pg_t lo);
        pg_t r;
        r.p = hi.p & lo.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction
endpackage

// File: rtl/hcsa_pg_cell4.sv
module hcsa_pg_cell4
    import hcsa_pkg::*;
(
    input  pg_t r0,
    input  pg_t r1,
    input  pg_t r2,
    input  pg_t r3,
    output pg_t span01,
    output pg_t span012,
    output pg_t span0123
);
    // r0 is the lowest range; the outputs are cumulative prefixes
    assign span01   = pg_merge(r1, r0);
    assign span012  = pg_merge(r2, span01);
    assign span0123 = pg_merge(r3, span012);
endmodule

// File: rtl/hcsa_cond_group.sv
module hcsa_cond_group #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_c0,
    output logic [W-1:0] sum_c1,
    output logic         cy_c0,
    output logic         cy_c1
);
    logic [W:0] rip0;
    logic [W:0] rip1;

    always_comb begin
        rip0[0] = 1'b0;
        rip1[0] = 1'b1;
        for (int i = 0; i < W; i++) begin
            rip0[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & rip0[i]);
            rip1[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & rip1[i]);
        end
    end

    assign sum_c0 = a ^ b ^ rip0[W-1:0];
    assign sum_c1 = a ^ b ^ rip1[W-1:0];
    assign cy_c0  = rip0[W];
    assign cy_c1  = rip1[W];

    // R3: the two ripple chains must land exactly one apart
    always_comb begin
        a_r3_pair_step: assert ({cy_c1, sum_c1} == {cy_c0, sum_c0} + (W+1)'(1))
            else $error("R3 conditional results not one apart");
        a_r3_carry_order: assert (!cy_c0 || cy_c1)
            else $error("R3 carry with c=0 but not with c=1");
    end
endmodule

// File: rtl/hcsa_carry_tree.sv
module hcsa_carry_tree
    import hcsa_pkg::*;
(
    input  logic [TREE_W-1:0]  a_lo,
    input  logic [TREE_W-1:0]  b_lo,
    input  logic               cin,
    output logic [NUM_GRP-1:0] grp_cin
);
    // bitwise propagate/generate, carry-in folded into bit 0
    pg_t bit_pg [TREE_W];
    for (genvar i = 0; i < TREE_W; i++) begin : g_bit
        if (i == 0) begin : g_fold
            assign bit_pg[i].p = a_lo[i] ^ b_lo[i];
            assign bit_pg[i].g = (a_lo[i] & b_lo[i]) | ((a_lo[i] ^ b_lo[i]) & cin);
        end else begin : g_plain
            assign bit_pg[i].p = a_lo[i] ^ b_lo[i];
            assign bit_pg[i].g = a_lo[i] & b_lo[i];
        end
    end

    // level 1: one cell per 4-bit range, full span used downstream
    pg_t nib     [NUM_NIB];
    pg_t nib_lo2 [NUM_NIB];
    pg_t nib_lo3 [NUM_NIB];
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_lv1
        hcsa_pg_cell4 u_cell (
            .r0      (bit_pg[NIB_W*n]),
            .r1      (bit_pg[NIB_W*n+1]),
            .r2      (bit_pg[NIB_W*n+2]),
            .r3      (bit_pg[NIB_W*n+3]),
            .span01  (nib_lo2[n]),
            .span012 (nib_lo3[n]),
            .span0123(nib[n])
        );
        // R8: a transparent range has transparent sub-ranges
        always_comb begin
            a_r8_nib_prefix: assert (!nib[n].p || (nib_lo2[n].p && nib_lo3[n].p))
                else $error("R8 level-1 propagate inconsistent");
        end
    end

    // level 2
    pg_t s7_0, s11_0, s15_0;
    pg_t s23_16, s27_16, s31_16;
    pg_t s39_32, s43_32, s47_32;
    pg_t s55_48, s55_48b, s55_48c;

    hcsa_pg_cell4 u_lv2_a (.r0(nib[0]), .r1(nib[1]), .r2(nib[2]), .r3(nib[3]),
                           .span01(s7_0), .span012(s11_0), .span0123(s15_0));
    hcsa_pg_cell4 u_lv2_b (.r0(nib[4]), .r1(nib[5]), .r2(nib[6]), .r3(nib[7]),
                           .span01(s23_16), .span012(s27_16), .span0123(s31_16));
    hcsa_pg_cell4 u_lv2_c (.r0(nib[8]), .r1(nib[9]), .r2(nib[10]), .r3(nib[11]),
                           .span01(s39_32), .span012(s43_32), .span0123(s47_32));
    hcsa_pg_cell4 u_lv2_d (.r0(nib[12]), .r1(nib[13]), .r2(PG_IDENT), .r3(PG_IDENT),
                           .span01(s55_48), .span012(s55_48b), .span0123(s55_48c));

    always_comb begin
        a_r8_lv2_prefix: assert ((!s15_0.p || s11_0.p) && (!s31_16.p || s27_16.p) &&
                                 (!s47_32.p || s43_32.p))
            else $error("R8 level-2 propagate inconsistent");
        a_r8_pad_neutral: assert (s55_48b == s55_48 && s55_48c == s55_48)
            else $error("R8 identity padding altered a range");
    end

    // level 3: overlapping inputs give several carries per cell
    pg_t x23_0, x31_0, x39_0;
    pg_t t31_0, t47_0, t55_0;

    hcsa_pg_cell4 u_lv3_a (.r0(s15_0), .r1(s23_16), .r2(s31_16), .r3(s39_32),
                           .span01(x23_0), .span012(x31_0), .span0123(x39_0));
    hcsa_pg_cell4 u_lv3_b (.r0(s15_0), .r1(s31_16), .r2(s47_32), .r3(s55_48),
                           .span01(t31_0), .span012(t47_0), .span0123(t55_0));

    always_comb begin
        a_r7_paths_agree: assert (t31_0 == x31_0)
            else $error("R7 two prefixes over bits 31:0 differ");
    end

    assign grp_cin = {t55_0.g, t47_0.g, x39_0.g, x31_0.g, x23_0.g, s15_0.g, s7_0.g, cin};
endmodule

// File: rtl/hybrid_csla_adder.sv
module hybrid_csla_adder
    import hcsa_pkg::*;
(
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    input  logic             cin,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    logic [NUM_GRP-1:0] grp_cin;
    logic [NUM_GRP-1:0] cy0;
    logic [NUM_GRP-1:0] cy1;
    logic [GRP_W-1:0]   s0 [NUM_GRP];
    logic [GRP_W-1:0]   s1 [NUM_GRP];

    hcsa_carry_tree u_tree (
        .a_lo   (a[TREE_W-1:0]),
        .b_lo   (b[TREE_W-1:0]),
        .cin    (cin),
        .grp_cin(grp_cin)
    );

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_slice
        hcsa_cond_group #(.W(GRP_W)) u_grp (
            .a     (a[GRP_W*k +: GRP_W]),
            .b     (b[GRP_W*k +: GRP_W]),
            .sum_c0(s0[k]),
            .sum_c1(s1[k]),
            .cy_c0 (cy0[k]),
            .cy_c1 (cy1[k])
        );
        assign sum[GRP_W*k +: GRP_W] = grp_cin[k] ? s1[k] : s0[k];

        if (k > 0) begin : g_chk
            // R4: tree carry matches the lower slice's selected carry-out
            always_comb begin
                a_r4_carry_chain: assert (grp_cin[k] == (grp_cin[k-1] ? cy1[k-1] : cy0[k-1]))
                    else $error("R4 tree carry disagrees with slice below");
            end
        end
    end

    assign cout = grp_cin[NUM_GRP-1] ? cy1[NUM_GRP-1] : cy0[NUM_GRP-1];
endmodule

// File: tb/sim_hybrid_csla_adder.sv
`timescale 1ns/1ps
module sim_hybrid_csla_adder;
    logic        clk = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        cin = 1'b0;
    logic [63:0] sum;
    logic        cout;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hybrid_csla_adder u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

    function automatic logic [64:0] ref_add(logic [63:0] x, logic [63:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {64'd0, c};
    endfunction

    task automatic apply(input logic [63:0] x, input logic [63:0] y,
                         input logic c, input string tag);
        logic [64:0] exp;
        @(negedge clk);
        a = x; b = y; cin = c;
        #5;
        exp = ref_add(x, y, c);
        total++;
        if (sum !== exp[63:0]) begin
            bad++;
            $display("FAIL %s sum: a=%h b=%h cin=%b got %h expected %h",
                     tag, x, y, c, sum, exp[63:0]);
        end
        total++;
        if (cout !== exp[64]) begin
            bad++;
            $display("FAIL %s cout: a=%h b=%h cin=%b got %b expected %b",
                     tag, x, y, c, cout, exp[64]);
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);

        // R1 R2: zero operands give zero
        apply(64'd0, 64'd0, 1'b0, "R1_zero");
        apply(64'd5, 64'd7, 1'b0, "R2_small");
        // R5: carry input absorbed at the bottom and rippled to the top
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, "R5_cin_fold");
        apply(64'd0, 64'd0, 1'b1, "R5_cin_only");
        // R6: all-propagate with no carry input
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R6_ones_zero");
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R6_alt");
        // R8: all-propagate with carry input travels full width
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R8_alt_cin");
        apply(64'h0F0F_F0F0_3C3C_C3C3, 64'hF0F0_0F0F_C3C3_3C3C, 1'b1, "R8_mixed_cin");
        // R7: carry out of bit 31 into bit 32
        apply(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, "R7_bit32");
        apply(64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, "R7_bit32_cin");
        // R4: carry across every slice boundary
        for (int k = 1; k < 8; k++) begin
            apply((64'd1 << (8*k)) - 64'd1, 64'd1, 1'b0, "R4_boundary");
        end
        // R2: overflow out of the top slice
        apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R2_top_gen");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2_all_ones");
        // R3: alternating generate runs exercise both slice results
        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R3_alt_gen");
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, "R3_slice_pairs");
        // R1 R2: random operands
        for (int i = 0; i < 600; i++) begin
            logic [63:0] x;
            logic [63:0] y;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (i % 5 == 0) y = ~x;
            apply(x, y, 1'($urandom), "R1_R2_random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule